// File: doc/BRIEF.md
# Shadow Memory Store/Recall Engine

This block pairs a byte-wide working memory with a nonvolatile shadow array of identical size, together with the sequencer that moves data between the two. A host port gives single-cycle reads and writes to the working memory. A command decoder outside the block issues one-cycle start pulses for a store or a recall.

A store runs in two fixed phases. First it erases the whole shadow array by setting every location to all-ones. Then it programs each shadow byte from the working memory, in ascending address order, with a fixed number of cycles per byte. A recall copies the shadow array back into the working memory at one byte per cycle.

While either operation runs, a busy flag is high and the host port is shut out. Writes are dropped and reads return no valid data. When the operation finishes, a one-cycle done pulse marks the end and normal access resumes on its own. Both arrays are register arrays, and their depth is a parameter.

Top module: `shadow_mem_engine`

## Requirements
- R1: When busy is low, a host write (`host_en`=1, `host_we`=1) stores `host_wdata` at `host_addr`. A host read (`host_en`=1, `host_we`=0) makes `host_rvalid`=1 on the following cycle, with `host_rdata` equal to that location. On any cycle not preceded by an accepted read, `host_rvalid`=0 and `host_rdata`=0.
- R2: A `store_start` pulse accepted while idle raises `busy` on the next cycle and holds it for exactly DEPTH*(1+PROG_STEP) cycles, where DEPTH=2**ADDR_W.
- R3: A store first writes all-ones to every shadow location in ascending address order, one per cycle. Only after that does it program each shadow byte in ascending order, spending PROG_STEP cycles per byte. No byte is programmed into a location that has not been erased.
- R4: After a store, a recall restores into the working memory exactly the contents the working memory held when the store was accepted.
- R5: A `recall_start` pulse accepted while idle raises `busy` on the next cycle for exactly DEPTH cycles, and overwrites every working-memory location with the matching shadow byte.
- R6: While `busy` is high, host writes leave the working memory unchanged. Host reads produce `host_rvalid`=0 and `host_rdata`=0.
- R7: A `store_start` or `recall_start` that arrives while `busy` is high is ignored. The running operation neither restarts nor lengthens, and no second operation follows it.
- R8: `done` is high for exactly one cycle, which is the first cycle with `busy` low after an operation. A host access made in that cycle is accepted.
- R9: If `store_start` and `recall_start` arrive together while idle, only the store runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data, zero when not valid |
| host_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| store_start | input | 1 | Start-store pulse |
| recall_start | input | 1 | Start-recall pulse |
| busy | output | 1 | Store or recall in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The bench counts busy cycles for each operation and compares them with DEPTH*(1+PROG_STEP) and DEPTH. A sequencer that drops the final byte, or lets a start request arriving mid-operation restart it, gives the wrong count. Host writes and reads are issued during both operations. A leaky lockout would then corrupt the recalled image or hand back data while busy. Stores followed by overwrites and recalls, using patterns that include 0x00 and 0xFF, show whether the shadow really captured every byte. A program phase that merged with stale contents instead of erasing first is caught by the in-RTL check on erased locations. Simultaneous start pulses, and an access in the done cycle, cover the priority rule and whether access reopens.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ERASE  = 2'd1,
    PH_PROG   = 2'd2,
    PH_RECALL = 2'd3
  } phase_t;
endpackage

// File: rtl/smem_array.sv
module smem_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic cell_en;
    assign cell_en = we && (waddr == ADDR_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q[w] <= '0;
      else if (cell_en) cell_q[w] <= wdata;
    end
  end

  assign rdata_a = cell_q[raddr_a];
  assign rdata_b = cell_q[raddr_b];
endmodule

// File: rtl/smem_sequencer.sv
module smem_sequencer
  import smem_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PROG_STEP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_start,
  input  logic              recall_start,
  output phase_t            phase,
  output logic [ADDR_W-1:0] idx,
  output logic              fire,
  output logic              busy,
  output logic              done
);
  localparam int STEP_W = (PROG_STEP > 1) ? $clog2(PROG_STEP) : 1;
  localparam logic [ADDR_W-1:0] IDX_LAST  = '1;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(PROG_STEP - 1);

  phase_t            state_q, state_n;
  logic [ADDR_W-1:0] idx_q, idx_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic              done_q, done_n;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    step_n  = step_q;
    done_n  = 1'b0;
    fire    = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (store_start) begin
          state_n = PH_ERASE;
          idx_n   = '0;
          step_n  = '0;
        end else if (recall_start) begin
          state_n = PH_RECALL;
          idx_n   = '0;
        end
      end
      PH_ERASE: begin
        fire = 1'b1;
        if (idx_q == IDX_LAST) begin
          state_n = PH_PROG;
          idx_n   = '0;
          step_n  = '0;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      PH_PROG: begin
        if (step_q == STEP_LAST) begin
          fire   = 1'b1;
          step_n = '0;
          if (idx_q == IDX_LAST) begin
            state_n = PH_IDLE;
            done_n  = 1'b1;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end else begin
          step_n = step_q + 1'b1;
        end
      end
      PH_RECALL: begin
        fire = 1'b1;
        if (idx_q == IDX_LAST) begin
          state_n = PH_IDLE;
          done_n  = 1'b1;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      default: state_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      idx_q   <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      step_q  <= step_n;
      done_q  <= done_n;
    end
  end

  assign phase = state_q;
  assign idx   = idx_q;
  assign busy  = (state_q != PH_IDLE);
  assign done  = done_q;

  // R3: the erase phase may only lead into programming
  assert_erase_then_prog_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_ERASE) |=> (state_q == PH_ERASE || state_q == PH_PROG));
  // R3: programming is only entered from the erase phase
  assert_prog_after_erase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == PH_PROG) |-> ($past(state_q) == PH_ERASE));
  // R8: done lasts a single cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8: done follows a busy cycle and sits in idle
  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == PH_IDLE && $past(state_q) != PH_IDLE));
  // R7: a running recall is never turned into a store
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_RECALL) |=> (state_q == PH_RECALL || state_q == PH_IDLE));
endmodule

// File: rtl/shadow_mem_engine.sv
module shadow_mem_engine
  import smem_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int PROG_STEP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic              store_start,
  input  logic              recall_start,
  output logic              busy,
  output logic              done
);
  phase_t            phase;
  logic [ADDR_W-1:0] idx;
  logic              fire;

  logic              work_we, shadow_we;
  logic [ADDR_W-1:0] work_waddr;
  logic [DATA_W-1:0] work_wdata, shadow_wdata;
  logic [DATA_W-1:0] work_host_rd, work_eng_rd;
  logic [DATA_W-1:0] shadow_rd, shadow_unused;
  logic              host_wr_ok, host_rd_ok;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  smem_sequencer #(.ADDR_W(ADDR_W), .PROG_STEP(PROG_STEP)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .store_start(store_start), .recall_start(recall_start),
    .phase(phase), .idx(idx), .fire(fire), .busy(busy), .done(done)
  );

  assign host_wr_ok = host_en &&  host_we && !busy;
  assign host_rd_ok = host_en && !host_we && !busy;

  always_comb begin
    if (phase == PH_RECALL) begin
      work_we    = fire;
      work_waddr = idx;
      work_wdata = shadow_rd;
    end else begin
      work_we    = host_wr_ok;
      work_waddr = host_addr;
      work_wdata = host_wdata;
    end
  end

  assign shadow_we    = fire && (phase == PH_ERASE || phase == PH_PROG);
  assign shadow_wdata = (phase == PH_ERASE) ? {DATA_W{1'b1}} : work_eng_rd;

  smem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_work (
    .clk(clk), .rst_n(rst_n),
    .we(work_we), .waddr(work_waddr), .wdata(work_wdata),
    .raddr_a(host_addr), .rdata_a(work_host_rd),
    .raddr_b(idx), .rdata_b(work_eng_rd)
  );

  smem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .we(shadow_we), .waddr(idx), .wdata(shadow_wdata),
    .raddr_a(idx), .rdata_a(shadow_rd),
    .raddr_b(idx), .rdata_b(shadow_unused)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= host_rd_ok;
      if (host_rd_ok) rdata_q <= work_host_rd;
    end
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = rvalid_q ? rdata_q : '0;

  // R3: a byte is only programmed into an erased location
  assert_prog_on_erased_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PROG && fire) |-> (shadow_rd == {DATA_W{1'b1}}));
  // R6: no read data is presented for a request made while busy
  assert_locked_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_en && !host_we) |=> !host_rvalid);
  // R1: output data is zero whenever it is not valid
  assert_quiet_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rvalid |-> (host_rdata == '0));
endmodule

// File: tb/tb_shadow_mem_engine.sv
module tb_shadow_mem_engine;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;
  localparam int PROG_STEP = 3;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int STORE_CYC = DEPTH * (1 + PROG_STEP);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_en = 1'b0, host_we = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic [DATA_W-1:0] host_rdata;
  logic              host_rvalid;
  logic              store_start = 1'b0, recall_start = 1'b0;
  logic              busy, done;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  shadow_mem_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_STEP(PROG_STEP)) dut (
    .clk(clk), .rst_n(rst_n),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .store_start(store_start), .recall_start(recall_start),
    .busy(busy), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int sel, input int a);
    case (sel)
      0: pat = DATA_W'(a * 37 + 5);
      1: pat = DATA_W'(~(a * 11 + 2));
      default: pat = (a % 2 == 0) ? {DATA_W{1'b0}} : {DATA_W{1'b1}};
    endcase
  endfunction

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b1; host_addr = ADDR_W'(a); host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input int a, input int exp);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0; host_addr = ADDR_W'(a);
    @(negedge clk);
    host_en = 1'b0;
    check({req, " rvalid"}, int'(host_rvalid), 1);
    check({req, " rdata"}, int'(host_rdata), exp);
  endtask

  task automatic fill(input int sel);
    for (int a = 0; a < DEPTH; a++) wr(a, pat(sel, a));
  endtask

  task automatic verify(input string req, input int sel);
    int bad;
    bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      host_en = 1'b1; host_we = 1'b0; host_addr = ADDR_W'(a);
      @(negedge clk);
      host_en = 1'b0;
      if (!host_rvalid || host_rdata != pat(sel, a)) begin
        bad++;
        $display("FAIL %s: addr=%0d actual=%0d expected=%0d", req, a,
                 int'(host_rdata), int'(pat(sel, a)));
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  // starts an op at a negedge; returns number of busy cycles; disturb adds stray host and start traffic
  task automatic run_op(input logic st, input logic rc, input bit disturb, output int n, output int done_seen);
    @(negedge clk);
    store_start = st; recall_start = rc;
    @(negedge clk);
    store_start = 1'b0; recall_start = 1'b0;
    n = 0;
    while (busy && n < 10000) begin
      n++;
      if (disturb) begin
        host_en = 1'b1; host_we = (n % 2 == 0); host_addr = ADDR_W'(n);
        host_wdata = 8'h5A;
        if (n == 3) store_start = 1'b1;
        if (n == 5) recall_start = 1'b1;
      end
      @(negedge clk);
      if (disturb) begin
        if (busy && host_rvalid) begin
          errors++; checks++;
          $display("FAIL R6: rvalid while busy actual=1 expected=0");
        end
        host_en = 1'b0; host_we = 1'b0;
        store_start = 1'b0; recall_start = 1'b0;
      end
    end
    done_seen = int'(done);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int n, d;
    repeat (3) @(negedge clk);
    check("R1 reset rvalid", int'(host_rvalid), 0);
    check("R1 reset rdata", int'(host_rdata), 0);
    check("R2 reset busy", int'(busy), 0);
    check("R8 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    fill(0);
    verify("R1 pattern0 readback", 0);
    @(negedge clk);
    check("R1 idle rvalid low", int'(host_rvalid), 0);
    check("R1 idle rdata zero", int'(host_rdata), 0);

    // plain store
    run_op(1'b1, 1'b0, 1'b0, n, d);
    check("R2 store busy cycles", n, STORE_CYC);
    check("R8 done at end of store", d, 1);
    // access in the done cycle
    host_en = 1'b1; host_we = 1'b0; host_addr = 4'd7;
    @(negedge clk);
    host_en = 1'b0;
    check("R8 done lasts one cycle", int'(done), 0);
    check("R8 read in done cycle valid", int'(host_rvalid), 1);
    check("R8 read in done cycle data", int'(host_rdata), int'(pat(0, 7)));
    verify("R4 working memory intact after store", 0);

    // overwrite then recall
    fill(1);
    verify("R1 pattern1 readback", 1);
    run_op(1'b0, 1'b1, 1'b0, n, d);
    check("R5 recall busy cycles", n, DEPTH);
    check("R8 done at end of recall", d, 1);
    verify("R4 R5 recall restores store image", 0);

    // store with stray traffic: writes ignored, late starts ignored
    fill(2);
    run_op(1'b1, 1'b0, 1'b1, n, d);
    check("R7 store not lengthened by starts", n, STORE_CYC);
    @(negedge clk);
    check("R7 no follow-on op after store", int'(busy), 0);
    verify("R6 writes ignored during store", 2);

    // recall with stray traffic after overwriting
    fill(0);
    run_op(1'b0, 1'b1, 1'b1, n, d);
    check("R7 recall not lengthened by starts", n, DEPTH);
    @(negedge clk);
    check("R7 no follow-on op after recall", int'(busy), 0);
    verify("R6 R3 recall gives erased+programmed image", 2);

    // simultaneous starts: store wins
    fill(1);
    run_op(1'b1, 1'b1, 1'b0, n, d);
    check("R9 simultaneous starts run store", n, STORE_CYC);
    verify("R9 working memory not recalled", 1);
    fill(0);
    run_op(1'b0, 1'b1, 1'b0, n, d);
    verify("R9 R3 shadow holds new store", 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule